// File: doc/BRIEF.md
# DMA Thread Lifecycle State Controller

This block follows the operating state of a single DMA thread inside a multi-thread DMA engine. Decoded instruction strobes move the thread between its states. So do cache and PC-update handshakes, event signalling, drain and peripheral indications, bus-error flags and a watchdog abort. The block then reports the current state together with two flags that the fetch and arbitration logic use.

A parameter selects the flavour. A channel thread has barriers, peripheral waits, kill and completion phases, and a two-step fault path. A manager thread has a shorter life: it ends straight to Stopped, and it faults directly. Instruction decode, the cache, the address arithmetic and the bus itself sit outside this block. They only show up here as single-cycle strobes and level inputs.

Top module: `dma_thread_state`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) places the thread in Stopped. The state codes on `state_o` are Stopped=0, Executing=1, CacheMiss=2, UpdatingPc=3, WaitEvent=4, Barrier=5, WaitPeriph=6, Killing=7, Completing=8, FaultCompleting=9, Faulted=10.
- R2: A `go_i` pulse in Stopped moves the thread to Executing on the next edge. In any other state `go_i` is ignored.
- R3: `pc_valid_o` and `arb_elig_o` are high exactly while the state is Executing.
- R4: In Executing, `miss_i` moves the thread to CacheMiss. It stays there until `fill_done_i`, then returns to Executing.
- R5: In Executing, `pc_req_i` moves the thread to UpdatingPc. It stays there until `pc_done_i`, then returns to Executing.
- R6: In Executing, `wfe_i` moves the thread to WaitEvent and captures `evt_num_i`. The thread returns to Executing only on a `sev_i` whose `evt_num_i` equals the captured number. A `sev_i` with any other number is ignored.
- R7: A channel thread in Executing goes to Barrier on `rmb_i`, `wmb_i`, `flushp_i` or `align_upd_i`, and leaves to Executing on `drained_i`.
- R8: A channel thread in Executing goes to WaitPeriph on `wfp_i`, and leaves to Executing on `periph_req_i`.
- R9: For a channel thread, `kill_i` leads to Killing and `end_i` leads to Completing. Both go to Stopped on `drained_i`. A manager thread goes from Executing to Stopped on `end_i`, and it ignores `kill_i`, `wfp_i` and the barrier strobes.
- R10: A channel thread in any active state (not Stopped, FaultCompleting or Faulted) goes to FaultCompleting on `fetch_err_i`, on `data_err_i`, or on `undef_i` while Executing. FaultCompleting moves to Faulted on `drained_i`. `wdog_abort_i` in an active state goes straight to Faulted and wins over the other fault causes.
- R11: A manager thread in an active state goes to Faulted on `fetch_err_i`, or on `undef_i` while Executing. It ignores `data_err_i` and `wdog_abort_i`.
- R12: Faulted is left only on `clear_i`, which returns the thread to Stopped.
- R13: When several strobes arrive together in Executing, the order of precedence is: fault, then kill, then end, then cache miss, then PC update, then wait-for-event, then barrier, then peripheral wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Start command for this thread |
| end_i | input | 1 | End instruction decoded |
| wfe_i | input | 1 | Wait-for-event instruction decoded |
| sev_i | input | 1 | Send-event seen on the event bus |
| wfp_i | input | 1 | Wait-for-peripheral instruction decoded |
| kill_i | input | 1 | Kill instruction decoded |
| rmb_i | input | 1 | Read barrier instruction decoded |
| wmb_i | input | 1 | Write barrier instruction decoded |
| flushp_i | input | 1 | Peripheral flush instruction decoded |
| align_upd_i | input | 1 | Alignment-affecting control update |
| undef_i | input | 1 | Undefined or invalid instruction |
| miss_i | input | 1 | Next instruction missed in the cache |
| fill_done_i | input | 1 | Cache line fill finished |
| pc_req_i | input | 1 | Next-access address must be computed |
| pc_done_i | input | 1 | Address computation finished |
| evt_num_i | input | EVW | Event number for wait or send |
| fetch_err_i | input | 1 | Bus error on instruction fetch |
| data_err_i | input | 1 | Bus error on data transfer |
| wdog_abort_i | input | 1 | Watchdog abort |
| drained_i | input | 1 | Outstanding transfers drained |
| periph_req_i | input | 1 | Peripheral request arrived |
| clear_i | input | 1 | External clear of a faulted thread |
| state_o | output | 4 | Current state code |
| pc_valid_o | output | 1 | PC valid flag |
| arb_elig_o | output | 1 | Thread eligible for arbitration |

## Verification
Every transition is registered once. A strobe applied before a clock edge therefore shows on `state_o` and on both flags right after that edge, with no further delay. The bench drives inputs just after the falling edge, so each strobe is seen by exactly one rising edge. It then compares the outputs at the next falling edge against a behavioural model that advanced on the same rising edge. One channel instance and one manager instance run side by side from shared stimulus, so every mixed-strobe cycle checks both flavours.

// File: rtl/dma_thread_state.sv
module dma_thread_state #(
  parameter bit IS_CHANNEL = 1'b1,
  parameter int EVW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_i,
  input  logic           end_i,
  input  logic           wfe_i,
  input  logic           sev_i,
  input  logic           wfp_i,
  input  logic           kill_i,
  input  logic           rmb_i,
  input  logic           wmb_i,
  input  logic           flushp_i,
  input  logic           align_upd_i,
  input  logic           undef_i,
  input  logic           miss_i,
  input  logic           fill_done_i,
  input  logic           pc_req_i,
  input  logic           pc_done_i,
  input  logic [EVW-1:0] evt_num_i,
  input  logic           fetch_err_i,
  input  logic           data_err_i,
  input  logic           wdog_abort_i,
  input  logic           drained_i,
  input  logic           periph_req_i,
  input  logic           clear_i,
  output logic [3:0]     state_o,
  output logic           pc_valid_o,
  output logic           arb_elig_o
);

  typedef enum logic [3:0] {
    S_STOP  = 4'd0,
    S_EXEC  = 4'd1,
    S_CMISS = 4'd2,
    S_UPDPC = 4'd3,
    S_WFE   = 4'd4,
    S_BARR  = 4'd5,
    S_WFP   = 4'd6,
    S_KILL  = 4'd7,
    S_CMPL  = 4'd8,
    S_FCMPL = 4'd9,
    S_FAULT = 4'd10
  } thr_state_e;

  localparam bit CH = IS_CHANNEL;

  thr_state_e st_q, st_d;
  logic [EVW-1:0] evt_q;
  logic active, fault_hit, barrier_hit;

  assign active      = !(st_q inside {S_STOP, S_FCMPL, S_FAULT});
  assign fault_hit   = ((st_q == S_EXEC) && undef_i) || fetch_err_i || (CH && data_err_i);
  assign barrier_hit = CH && (rmb_i || wmb_i || flushp_i || align_upd_i);

  always_comb begin
    st_d = st_q;
    if (active && CH && wdog_abort_i)
      st_d = S_FAULT;
    else if (active && fault_hit)
      st_d = CH ? S_FCMPL : S_FAULT;
    else begin
      case (st_q)
        S_STOP:  if (go_i) st_d = S_EXEC;
        S_EXEC: begin
          if (CH && kill_i)      st_d = S_KILL;
          else if (end_i)        st_d = CH ? S_CMPL : S_STOP;
          else if (miss_i)       st_d = S_CMISS;
          else if (pc_req_i)     st_d = S_UPDPC;
          else if (wfe_i)        st_d = S_WFE;
          else if (barrier_hit)  st_d = S_BARR;
          else if (CH && wfp_i)  st_d = S_WFP;
        end
        S_CMISS: if (fill_done_i) st_d = S_EXEC;
        S_UPDPC: if (pc_done_i) st_d = S_EXEC;
        S_WFE:   if (sev_i && (evt_num_i == evt_q)) st_d = S_EXEC;
        S_BARR:  if (drained_i) st_d = S_EXEC;
        S_WFP:   if (periph_req_i) st_d = S_EXEC;
        S_KILL,
        S_CMPL:  if (drained_i) st_d = S_STOP;
        S_FCMPL: if (drained_i) st_d = S_FAULT;
        S_FAULT: if (clear_i) st_d = S_STOP;
        default: st_d = S_STOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_STOP;
      evt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_EXEC && wfe_i) evt_q <= evt_num_i;
    end
  end

  assign state_o    = st_q;
  assign pc_valid_o = (st_q == S_EXEC);
  assign arb_elig_o = (st_q == S_EXEC);

  AST_START_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == S_STOP && st_q == S_EXEC) |-> $past(go_i)); // R2
  AST_FILL_BEFORE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == S_CMISS && st_q == S_EXEC) |-> $past(fill_done_i)); // R4
  AST_EVENT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == S_WFE && st_q == S_EXEC) |-> ($past(sev_i) && $past(evt_num_i) == $past(evt_q))); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == S_FAULT && !$past(clear_i)) |-> st_q == S_FAULT); // R12
  AST_KILL_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == S_KILL && st_q == S_STOP) |-> $past(drained_i)); // R9
  AST_FLAGS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_valid_o || arb_elig_o) |-> ($past(st_d) == S_EXEC)); // R3

  generate
    if (!IS_CHANNEL) begin : g_mgr_chk
      always_comb
        AST_MGR_NO_CH_STATE: assert (!rst_n || !(st_q inside {S_BARR, S_WFP, S_KILL, S_CMPL, S_FCMPL})); // R11
    end
  endgenerate

endmodule

// File: tb/dma_thread_state_bench.sv
`timescale 1ns/1ps
module dma_thread_state_bench;
  localparam int EVW = 5;
  logic clk = 0, rst_n = 0;
  logic go, en, wfe, sev, wfp, kill, rmb, wmb, flushp, alignu, undef, miss, fill, pcr, pcd;
  logic [EVW-1:0] evn;
  logic ferr, derr, wdog, drn, preq, clr;
  logic [3:0] st_c, st_m;
  logic pv_c, ae_c, pv_m, ae_m;
  int checks = 0, failures = 0, cyc = 0;
  string tag = "R1";
  int mc, mm;
  logic [EVW-1:0] ec, em;

  always #4 clk = ~clk;

  dma_thread_state #(.IS_CHANNEL(1'b1), .EVW(EVW)) u_dma_thread_state (
    .clk(clk), .rst_n(rst_n), .go_i(go), .end_i(en), .wfe_i(wfe), .sev_i(sev), .wfp_i(wfp),
    .kill_i(kill), .rmb_i(rmb), .wmb_i(wmb), .flushp_i(flushp), .align_upd_i(alignu),
    .undef_i(undef), .miss_i(miss), .fill_done_i(fill), .pc_req_i(pcr), .pc_done_i(pcd),
    .evt_num_i(evn), .fetch_err_i(ferr), .data_err_i(derr), .wdog_abort_i(wdog),
    .drained_i(drn), .periph_req_i(preq), .clear_i(clr),
    .state_o(st_c), .pc_valid_o(pv_c), .arb_elig_o(ae_c));

  dma_thread_state #(.IS_CHANNEL(1'b0), .EVW(EVW)) u_dma_thread_state_mgr (
    .clk(clk), .rst_n(rst_n), .go_i(go), .end_i(en), .wfe_i(wfe), .sev_i(sev), .wfp_i(wfp),
    .kill_i(kill), .rmb_i(rmb), .wmb_i(wmb), .flushp_i(flushp), .align_upd_i(alignu),
    .undef_i(undef), .miss_i(miss), .fill_done_i(fill), .pc_req_i(pcr), .pc_done_i(pcd),
    .evt_num_i(evn), .fetch_err_i(ferr), .data_err_i(derr), .wdog_abort_i(wdog),
    .drained_i(drn), .periph_req_i(preq), .clear_i(clr),
    .state_o(st_m), .pc_valid_o(pv_m), .arb_elig_o(ae_m));

  function automatic int step(bit ch, int s, logic [EVW-1:0] ev);
    bit live = (s != 0 && s != 9 && s != 10);
    if (live && ch && wdog) return 10;
    if (live && ((s == 1 && undef) || ferr || (ch && derr))) return ch ? 9 : 10;
    if (s == 0) return go ? 1 : 0;
    if (s == 1) begin
      if (ch && kill) return 7;
      if (en) return ch ? 8 : 0;
      if (miss) return 2;
      if (pcr) return 3;
      if (wfe) return 4;
      if (ch && (rmb || wmb || flushp || alignu)) return 5;
      if (ch && wfp) return 6;
      return 1;
    end
    if (s == 2) return fill ? 1 : 2;
    if (s == 3) return pcd ? 1 : 3;
    if (s == 4) return (sev && evn == ev) ? 1 : 4;
    if (s == 5) return drn ? 1 : 5;
    if (s == 6) return preq ? 1 : 6;
    if (s == 7 || s == 8) return drn ? 0 : s;
    if (s == 9) return drn ? 10 : 9;
    return clr ? 0 : 10;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc <= 0; mm <= 0; ec <= '0; em <= '0;
    end else begin
      mc <= step(1'b1, mc, ec);
      mm <= step(1'b0, mm, em);
      if (mc == 1 && wfe) ec <= evn;
      if (mm == 1 && wfe) em <= evn;
    end
  end

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", t, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk({tag, " channel state"}, int'(st_c), mc);
    chk({tag, " manager state"}, int'(st_m), mm);
    chk("R3 channel flags", {pv_c, ae_c}, (mc == 1) ? 3 : 0);
    chk("R3 manager flags", {pv_m, ae_m}, (mm == 1) ? 3 : 0);
    if (cyc > 5000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<5000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic clrall();
    {go, en, wfe, sev, wfp, kill, rmb, wmb, flushp, alignu, undef, miss, fill, pcr, pcd} = '0;
    {ferr, derr, wdog, drn, preq, clr} = '0;
    evn = '0;
  endtask

  task automatic tick(string t);
    @(negedge clk); #1; clrall(); tag = t;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    clrall();
    repeat (3) @(negedge clk);
    chk("R1 reset channel", int'(st_c), 0);
    chk("R1 reset manager", int'(st_m), 0);
    #1 rst_n = 1;
    idle(2);
    tick("R2"); go = 1;
    tick("R2"); go = 1;
    idle(1);
    tick("R4"); miss = 1; idle(3);
    tick("R4"); fill = 1;
    tick("R5"); pcr = 1; idle(2);
    tick("R5"); pcd = 1;
    tick("R6"); wfe = 1; evn = 5;
    tick("R6"); sev = 1; evn = 3; idle(1);
    tick("R6"); sev = 1; evn = 5;
    tick("R7"); rmb = 1; idle(2);
    tick("R7"); drn = 1;
    tick("R7"); wmb = 1;
    tick("R7"); drn = 1;
    tick("R7"); flushp = 1;
    tick("R7"); drn = 1;
    tick("R7"); alignu = 1;
    tick("R7"); drn = 1;
    tick("R8"); wfp = 1; idle(2);
    tick("R8"); preq = 1;
    tick("R13"); en = 1; miss = 1; wfe = 1;
    tick("R9"); drn = 1;
    tick("R2"); go = 1;
    tick("R13"); kill = 1; en = 1; pcr = 1;
    tick("R9"); go = 1;
    tick("R9"); drn = 1;
    tick("R2"); go = 1;
    tick("R13"); undef = 1; kill = 1; en = 1;
    tick("R10"); drn = 1;
    tick("R12"); go = 1; idle(1);
    tick("R12"); clr = 1;
    tick("R2"); go = 1;
    tick("R10"); miss = 1;
    tick("R11"); derr = 1; idle(1);
    tick("R10"); fill = 1; drn = 1;
    tick("R12"); clr = 1;
    tick("R2"); go = 1;
    tick("R11"); wdog = 1;
    tick("R12"); clr = 1;
    tick("R2"); go = 1;
    tick("R10"); wfe = 1; evn = 9;
    tick("R11"); ferr = 1;
    tick("R10"); drn = 1;
    tick("R12"); clr = 1;
    tick("R2"); go = 1;
    tick("R11"); undef = 1;
    tick("R12"); clr = 1;
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule